// File: doc/BRIEF.md
# Invert-Based 32-bit ALU with Function Decoder

This block is the combinational arithmetic and logic unit of a simple processor datapath. Every bit position shares one structure: the A operand is optionally inverted, the B operand is optionally inverted, and a 2-bit selector then picks the AND of the two, the OR of the two, the adder sum or a set-less-than bit. The unit offers six functions: and, or, add, subtract, signed set-less-than and nor. Subtract adds the inverted B with a carry-in of one. Nor is the AND of both inverted operands. No separate gate path exists for any function.

A decoder in front of the datapath produces the invert bits and the selector from a 2-bit operation class and a 6-bit function field. The memory-address path uses the add class. The branch-compare path uses the subtract class. Register-to-register instructions use the function-decode class. The outputs are the result, a zero flag that the branch-equal decision reads, a signed-overflow flag that the exception logic reads, and an invalid-function flag. The block holds no state and has no states or transitions: every output follows its inputs in the same cycle.

Top module: `inv_alu`

## Requirements
- R1: When op_class is 2'b00, result is a + b modulo 2^32, whatever the value of func.
- R2: When op_class is 2'b01, result is a − b modulo 2^32, whatever the value of func.
- R3: When op_class is 2'b10, func 6'b100000 gives a + b, 6'b100100 gives a & b, and 6'b100101 gives a | b.
- R4: When op_class is 2'b10 and func is any code outside {100000, 100010, 100100, 100101, 101010, 100111}, the unit adds and bad_func is 1. In every other case bad_func is 0.
- R5: When op_class is 2'b10, func 6'b100010 gives a − b, formed as a + ~b + 1 modulo 2^32.
- R6: When op_class is 2'b10, func 6'b101010 gives result bit 0 equal to 1 exactly when a < b as signed 32-bit numbers, and bits 31:1 equal to 0. The compare is correct even when a − b overflows.
- R7: zero is 1 exactly when all 32 bits of result are 0.
- R8: ovf is 1 only for add and subtract. It is set when a signed add or subtract result does not fit in 32 bits. It is 0 for and, or, nor and set-less-than.
- R9: When op_class is 2'b10, func 6'b100111 gives ~(a | b).
- R10: When op_class is 2'b11, the unit adds and bad_func is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 2 | Operation class: 00 add, 01 subtract, 10 decode func, 11 add |
| func | input | 6 | Function field, read only under class 10 |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| result | output | 32 | Selected result |
| zero | output | 1 | 1 when result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |
| bad_func | output | 1 | Unrecognised function code under class 10 |

## Verification
The bench builds the unit at its default 32-bit width, so its reference model can use 64-bit signed integers to get the exact sum, difference and signed order.

The directed vectors cover the following cases:
- the ends of the signed range, where add and subtract overflow in both directions;
- compares whose difference overflows, which catches a set-less-than built from the sign bit alone;
- equal operands under subtract, which drive the zero flag;
- nor of zero operands.

Pseudo-random vectors then cover every class and function code, including unlisted codes.

// File: rtl/inv_alu_pkg.sv
package inv_alu_pkg;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } alu_sel_e;

    typedef struct packed {
        logic     a_inv;
        logic     b_inv;
        alu_sel_e sel;
    } alu_ctl_t;

    localparam int FUNC_W  = 6;
    localparam int CLASS_W = 2;

    localparam logic [CLASS_W-1:0] CLS_ADD  = 2'b00;
    localparam logic [CLASS_W-1:0] CLS_SUB  = 2'b01;
    localparam logic [CLASS_W-1:0] CLS_FUNC = 2'b10;
    localparam logic [CLASS_W-1:0] CLS_SPARE = 2'b11;

    localparam logic [FUNC_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNC_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNC_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNC_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNC_W-1:0] FN_SLT = 6'b101010;
    localparam logic [FUNC_W-1:0] FN_NOR = 6'b100111;

    localparam alu_ctl_t CTL_ADD = '{a_inv: 1'b0, b_inv: 1'b0, sel: SEL_SUM};
    localparam alu_ctl_t CTL_SUB = '{a_inv: 1'b0, b_inv: 1'b1, sel: SEL_SUM};
    localparam alu_ctl_t CTL_AND = '{a_inv: 1'b0, b_inv: 1'b0, sel: SEL_AND};
    localparam alu_ctl_t CTL_OR  = '{a_inv: 1'b0, b_inv: 1'b0, sel: SEL_OR};
    localparam alu_ctl_t CTL_SLT = '{a_inv: 1'b0, b_inv: 1'b1, sel: SEL_LESS};
    localparam alu_ctl_t CTL_NOR = '{a_inv: 1'b1, b_inv: 1'b1, sel: SEL_AND};

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import inv_alu_pkg::*;
(
    input  logic [CLASS_W-1:0] op_class,
    input  logic [FUNC_W-1:0]  func,
    output alu_ctl_t           ctl,
    output logic               bad_func
);

    always_comb begin
        ctl      = CTL_ADD;
        bad_func = 1'b0;
        unique case (op_class)
            CLS_ADD:   ctl = CTL_ADD;
            CLS_SUB:   ctl = CTL_SUB;
            CLS_FUNC: begin
                unique case (func)
                    FN_ADD:  ctl = CTL_ADD;
                    FN_SUB:  ctl = CTL_SUB;
                    FN_AND:  ctl = CTL_AND;
                    FN_OR:   ctl = CTL_OR;
                    FN_SLT:  ctl = CTL_SLT;
                    FN_NOR:  ctl = CTL_NOR;
                    default: begin
                        ctl      = CTL_ADD;
                        bad_func = 1'b1;
                    end
                endcase
            end
            CLS_SPARE: ctl = CTL_ADD;
            default:   ctl = CTL_ADD;
        endcase
    end

    always_comb begin
        if (bad_func) begin
            AST_BAD_ONLY_FUNC: assert (op_class == CLS_FUNC)
                else $error("bad_func outside function class"); // R4
        end
        if (op_class != CLS_FUNC) begin
            AST_CLASS_NO_BAD: assert (!bad_func)
                else $error("bad_func raised for fixed class"); // R10
        end
    end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import inv_alu_pkg::*;
(
    input  logic     a,
    input  logic     b,
    input  logic     cin,
    input  logic     less,
    input  alu_ctl_t ctl,
    output logic     sum,
    output logic     cout,
    output logic     res
);

    logic a_eff;
    logic b_eff;

    always_comb begin
        a_eff = a ^ ctl.a_inv;
        b_eff = b ^ ctl.b_inv;
        sum   = a_eff ^ b_eff ^ cin;
        cout  = (a_eff & b_eff) | (a_eff & cin) | (b_eff & cin);
        unique case (ctl.sel)
            SEL_AND:  res = a_eff & b_eff;
            SEL_OR:   res = a_eff | b_eff;
            SEL_SUM:  res = sum;
            SEL_LESS: res = less;
            default:  res = sum;
        endcase
    end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
    import inv_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_ctl_t         ctl,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum_bits;
    logic             less_bit;
    logic             raw_ovf;
    logic             a_top;
    logic             b_top;

    assign carry[0] = ctl.b_inv;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_slice
            if (i == 0) begin : g_lsb
                alu_bit_slice u_slice (
                    .a    (a[i]),
                    .b    (b[i]),
                    .cin  (carry[i]),
                    .less (less_bit),
                    .ctl  (ctl),
                    .sum  (sum_bits[i]),
                    .cout (carry[i+1]),
                    .res  (result[i])
                );
            end else begin : g_upper
                alu_bit_slice u_slice (
                    .a    (a[i]),
                    .b    (b[i]),
                    .cin  (carry[i]),
                    .less (1'b0),
                    .ctl  (ctl),
                    .sum  (sum_bits[i]),
                    .cout (carry[i+1]),
                    .res  (result[i])
                );
            end
        end
    endgenerate

    always_comb begin
        a_top    = a[MSB] ^ ctl.a_inv;
        b_top    = b[MSB] ^ ctl.b_inv;
        raw_ovf  = (a_top == b_top) && (sum_bits[MSB] != a_top);
        less_bit = sum_bits[MSB] ^ raw_ovf;
        ovf      = raw_ovf && (ctl.sel == SEL_SUM);
        zero     = ~|result;
    end

    always_comb begin
        if (ctl.sel == SEL_AND && ctl.a_inv && ctl.b_inv) begin
            AST_NOR_FORM: assert (result == ~(a | b))
                else $error("nor result mismatch"); // R9
        end
        if (ctl.sel == SEL_LESS) begin
            AST_LESS_UPPER: assert (result[MSB:1] == '0)
                else $error("slt upper bits set"); // R6
        end
        if (ovf) begin
            AST_OVF_ONLY_SUM: assert (ctl.sel == SEL_SUM)
                else $error("overflow outside adder select"); // R8
        end
    end

endmodule

// File: rtl/inv_alu.sv
module inv_alu
    import inv_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [1:0]       op_class,
    input  logic [5:0]       func,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             ovf,
    output logic             bad_func
);

    alu_ctl_t ctl;

    alu_op_decode u_decode (
        .op_class (op_class),
        .func     (func),
        .ctl      (ctl),
        .bad_func (bad_func)
    );

    alu_datapath #(.WIDTH(WIDTH)) u_datapath (
        .a      (a),
        .b      (b),
        .ctl    (ctl),
        .result (result),
        .zero   (zero),
        .ovf    (ovf)
    );

    always_comb begin
        if (op_class == CLS_ADD) begin
            AST_CLASS_ADD: assert (result == a + b)
                else $error("class add result mismatch"); // R1
        end
        if (op_class == CLS_SUB) begin
            AST_CLASS_SUB: assert (result == a - b)
                else $error("class sub result mismatch"); // R2
        end
        if (op_class == CLS_SUB && zero) begin
            AST_ZERO_EQUAL: assert (a == b && !ovf)
                else $error("zero on unequal subtract"); // R7
        end
    end

endmodule

// File: tb/inv_alu_bench.sv
module inv_alu_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  op_class;
    logic [5:0]  func;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] result;
    logic        zero;
    logic        ovf;
    logic        bad_func;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    inv_alu u_inv_alu (
        .op_class (op_class),
        .func     (func),
        .a        (a),
        .b        (b),
        .result   (result),
        .zero     (zero),
        .ovf      (ovf),
        .bad_func (bad_func)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic apply(input logic [1:0] c, input logic [5:0] f,
                         input logic [31:0] va, input logic [31:0] vb);
        longint sa, sb, full;
        logic [31:0] e_res;
        logic        e_ovf, e_bad;
        string       tag;
        int          kind;
        sa = longint'($signed(va));
        sb = longint'($signed(vb));
        e_bad = 1'b0;
        kind  = 0;
        tag   = "R1";
        if (c == 2'b00) begin kind = 0; tag = "R1"; end
        else if (c == 2'b01) begin kind = 1; tag = "R2"; end
        else if (c == 2'b11) begin kind = 0; tag = "R10"; end
        else begin
            case (f)
                6'b100000: begin kind = 0; tag = "R3"; end
                6'b100010: begin kind = 1; tag = "R5"; end
                6'b100100: begin kind = 2; tag = "R3"; end
                6'b100101: begin kind = 3; tag = "R3"; end
                6'b101010: begin kind = 4; tag = "R6"; end
                6'b100111: begin kind = 5; tag = "R9"; end
                default:   begin kind = 0; tag = "R4"; e_bad = 1'b1; end
            endcase
        end
        e_ovf = 1'b0;
        case (kind)
            0: begin
                full  = sa + sb;
                e_res = full[31:0];
                e_ovf = (full > 64'sd2147483647) || (full < -64'sd2147483648);
            end
            1: begin
                full  = sa - sb;
                e_res = full[31:0];
                e_ovf = (full > 64'sd2147483647) || (full < -64'sd2147483648);
            end
            2: e_res = va & vb;
            3: e_res = va | vb;
            4: e_res = (sa < sb) ? 32'd1 : 32'd0;
            default: e_res = ~(va | vb);
        endcase
        @(posedge clk);
        op_class = c; func = f; a = va; b = vb;
        @(negedge clk);
        check(tag, "result", result, e_res);
        check("R7", "zero", {31'd0, zero}, {31'd0, (e_res == 32'd0)});
        check("R8", "ovf", {31'd0, ovf}, {31'd0, e_ovf});
        check("R4", "bad_func", {31'd0, bad_func}, {31'd0, e_bad});
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        logic [5:0]  fn_list [0:7];
        fn_list[0] = 6'b100000; fn_list[1] = 6'b100010;
        fn_list[2] = 6'b100100; fn_list[3] = 6'b100101;
        fn_list[4] = 6'b101010; fn_list[5] = 6'b100111;
        fn_list[6] = 6'b000000; fn_list[7] = 6'b111111;
        op_class = 2'b00; func = 6'd0; a = '0; b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // idle operands: add of zeros reads back all-zero result (R7)
        check("R7", "idle result", result, 32'd0);
        check("R7", "idle zero", {31'd0, zero}, 32'd1);

        apply(2'b00, 6'b100100, 32'h7fffffff, 32'h00000001); // R1 ovf, func ignored
        apply(2'b00, 6'b101010, 32'h80000000, 32'h80000000); // R1 neg ovf, zero
        apply(2'b01, 6'b100101, 32'h80000000, 32'h00000001); // R2 ovf
        apply(2'b01, 6'b000000, 32'h12345678, 32'h12345678); // R2 zero
        apply(2'b10, 6'b100010, 32'h7fffffff, 32'hffffffff); // R5 ovf
        apply(2'b10, 6'b100010, 32'h00000005, 32'h00000009); // R5
        apply(2'b10, 6'b101010, 32'h80000000, 32'h00000001); // R6 overflowing compare
        apply(2'b10, 6'b101010, 32'h7fffffff, 32'hffffffff); // R6 overflowing compare
        apply(2'b10, 6'b101010, 32'hfffffffe, 32'hffffffff); // R6
        apply(2'b10, 6'b101010, 32'h00000003, 32'h00000003); // R6 equal
        apply(2'b10, 6'b100111, 32'h00000000, 32'h00000000); // R9
        apply(2'b10, 6'b100111, 32'hffffffff, 32'h00000000); // R9 zero
        apply(2'b10, 6'b100100, 32'hf0f0f0f0, 32'h0f0f0f0f); // R3 and zero
        apply(2'b10, 6'b100101, 32'hf0f0f0f0, 32'h0f0f0f0f); // R3 or
        apply(2'b10, 6'b100000, 32'h7fffffff, 32'h7fffffff); // R3 add ovf
        apply(2'b10, 6'b000001, 32'h00000010, 32'h00000020); // R4 invalid
        apply(2'b10, 6'b100110, 32'h7fffffff, 32'h00000001); // R4 invalid ovf
        apply(2'b11, 6'b100010, 32'h00000007, 32'h00000003); // R10

        lfsr = 32'hace1_2b3d;
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra, rb;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ra = lfsr * 32'h9e3779b1;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rb = lfsr ^ {lfsr[15:0], lfsr[31:16]};
            if (i % 7 == 0) rb = ra;
            apply(lfsr[5:4], fn_list[lfsr[10:8]], ra, rb);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule